// File: doc/BRIEF.md
# Post-Increment Load Unit

This unit executes one load at a time for a 64-bit register machine. The load address is the base register exactly as it stood when the operation was issued. After the data comes back, the base register is advanced by an offset. The offset is either a sign-extended immediate or the full value of an index register.

Each operation issues a single memory read and holds it until the memory reports valid data. It then presents two write-backs in the same cycle: the formatted load result goes to the target register, and the advanced base goes to the base register. An operation that names base register 0, or a base equal to the target, is rejected. In that case the unit raises a one-cycle invalid flag, makes no memory request and performs no writes.

The controller has four states:
- **IDLE** accepts an operation. It moves to **WAIT** on a valid form, or to **REJECT** on an invalid form.
- **WAIT** holds the memory request and moves to **WRITE** when the memory returns valid data.
- **WRITE** presents both write-backs for one cycle and returns to **IDLE**.
- **REJECT** raises the invalid flag for one cycle and returns to **IDLE**.

Top module: `pinc_load_unit`

## Requirements
- R1: The memory address is the base value captured at issue, with no offset added. The request stays asserted, with that address stable, from the cycle after issue until the cycle in which `mem_rvalid` is sampled high.
- R2: The base register write data equals the captured base plus an offset. In immediate form (`op_indexed`=0) the offset is the 16-bit immediate sign-extended to 64 bits. In indexed form it is the full 64-bit index value.
- R3: In immediate form with size code 3 (8 bytes), the two low bits of the immediate are replaced by zeros before sign extension, so the offset is a multiple of four.
- R4: Size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes, and `mem_size` carries the code. With `op_signed`=0, the 1-, 2- and 4-byte loads place the low bytes of `mem_rdata` in the low bits of the result and clear every upper bit.
- R5: With `op_signed`=1, 2- and 4-byte loads fill the upper bits with the top bit of the loaded value. `op_signed` has no effect on 1-byte and 8-byte loads.
- R6: An 8-byte load writes all 64 bits of `mem_rdata` unchanged.
- R7: An operation with `op_ra`=0 or `op_ra`=`op_rt` raises `invalid` for exactly the cycle after issue. It makes no memory request and asserts neither write enable.
- R8: Both write enables rise together for exactly one cycle, the cycle after `mem_rvalid` was sampled. `rt_waddr` carries the target number and `ra_waddr` carries the base number.
- R9: `busy` is high from the cycle after issue through the write-back or reject cycle. `op_valid` is ignored while `busy` is high.
- R10: A synchronous active-high reset returns the unit to IDLE with every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe, accepted when not busy |
| op_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| op_signed | input | 1 | Algebraic (sign-extending) load |
| op_indexed | input | 1 | Offset from index register instead of immediate |
| op_rt | input | 5 | Target register number |
| op_ra | input | 5 | Base register number |
| op_ra_val | input | 64 | Base register value |
| op_rb_val | input | 64 | Index register value |
| op_imm | input | 16 | Immediate field |
| busy | output | 1 | Operation in flight |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Read address |
| mem_size | output | 2 | Read size code |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Right-justified read data |
| rt_we | output | 1 | Target write enable |
| rt_waddr | output | 5 | Target register number |
| rt_wdata | output | 64 | Formatted load result |
| ra_we | output | 1 | Base write enable |
| ra_waddr | output | 5 | Base register number |
| ra_wdata | output | 64 | Advanced base value |
| invalid | output | 1 | Invalid form flag |

## Verification
Every size is tried with both settings of `op_signed`. The read data has its top loaded bit set and garbage in the bytes above it, which separates zero extension from sign extension and shows that upper bus bytes are discarded. Immediates are tried positive, negative and with nonzero low bits in both the 4-byte and 8-byte forms, which tells the scaled offset apart from the plain one. Index values include a wrap past zero. The reject cases cover base 0 and base equal to target. Memory latencies of zero to several cycles are used, with stray issue strobes sent while busy, so that capture at issue is distinguished from a live read of the inputs.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_REJECT = 2'd3
    } state_e;
endpackage

// File: rtl/pinc_offset.sv
module pinc_offset #(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  logic                indexed,
    input  pinc_pkg::size_e     size,
    input  logic [IMMW-1:0]     imm,
    input  logic [XLEN-1:0]     rb,
    output logic [XLEN-1:0]     offset
);
    localparam int EXTW = XLEN - IMMW;

    logic [IMMW-1:0] imm_adj;

    always_comb begin
        imm_adj = imm;
        // R3: scaled immediate form for 8-byte loads
        if (size == pinc_pkg::SZ_B8)
            imm_adj[1:0] = 2'b00;
    end

    always_comb begin
        if (indexed)
            offset = rb;
        else
            offset = {{EXTW{imm_adj[IMMW-1]}}, imm_adj};
    end
endmodule

// File: rtl/pinc_extend.sv
module pinc_extend #(
    parameter int XLEN = 64
) (
    input  pinc_pkg::size_e   size,
    input  logic              sign_en,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   result
);
    localparam int NSZ = 4;

    logic [XLEN-1:0] cand [NSZ];

    genvar g;
    generate
        for (g = 0; g < NSZ; g++) begin : g_sz
            localparam int W = 8 << g;
            if (W >= XLEN) begin : g_full
                assign cand[g] = rdata;
            end else if (g == 0) begin : g_byte
                assign cand[g] = {{(XLEN-W){1'b0}}, rdata[W-1:0]};
            end else begin : g_part
                logic fill;
                assign fill    = sign_en & rdata[W-1];
                assign cand[g] = {{(XLEN-W){fill}}, rdata[W-1:0]};
            end
        end
    endgenerate

    always_comb begin
        unique case (size)
            pinc_pkg::SZ_B1: result = cand[0];
            pinc_pkg::SZ_B2: result = cand[1];
            pinc_pkg::SZ_B4: result = cand[2];
            pinc_pkg::SZ_B8: result = cand[3];
            default:         result = cand[3];
        endcase
    end
endmodule

// File: rtl/pinc_ctrl.sv
module pinc_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic op_valid,
    input  logic form_bad,
    input  logic mem_rvalid,
    output logic take_op,
    output logic take_data,
    output logic busy,
    output logic mem_req,
    output logic wb_en,
    output logic invalid
);
    import pinc_pkg::*;

    state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        take_op   = 1'b0;
        take_data = 1'b0;
        busy      = 1'b1;
        mem_req   = 1'b0;
        wb_en     = 1'b0;
        invalid   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (op_valid) begin
                    take_op  = 1'b1;
                    state_nx = form_bad ? ST_REJECT : ST_WAIT;
                end
            end
            ST_WAIT: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    take_data = 1'b1;
                    state_nx  = ST_WRITE;
                end
            end
            ST_WRITE: begin
                wb_en    = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_REJECT: begin
                invalid  = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assert_no_write_on_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (!wb_en && !mem_req));
    assert_reject_follows_bad_R7: assert property (@(posedge clk) disable iff (rst)
        (take_op && form_bad) |=> invalid);
    assert_req_implies_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    assert_wb_after_data_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid) |=> (wb_en && !mem_req));
    assert_wb_single_R8: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> !wb_en);
endmodule

// File: rtl/pinc_load_unit.sv
module pinc_load_unit #(
    parameter int XLEN = 64,
    parameter int REGW = 5,
    parameter int IMMW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_size,
    input  logic             op_signed,
    input  logic             op_indexed,
    input  logic [REGW-1:0]  op_rt,
    input  logic [REGW-1:0]  op_ra,
    input  logic [XLEN-1:0]  op_ra_val,
    input  logic [XLEN-1:0]  op_rb_val,
    input  logic [IMMW-1:0]  op_imm,
    output logic             busy,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    output logic [1:0]       mem_size,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             rt_we,
    output logic [REGW-1:0]  rt_waddr,
    output logic [XLEN-1:0]  rt_wdata,
    output logic             ra_we,
    output logic [REGW-1:0]  ra_waddr,
    output logic [XLEN-1:0]  ra_wdata,
    output logic             invalid
);
    import pinc_pkg::*;

    logic            form_bad, take_op, take_data, wb_en;
    logic [XLEN-1:0] offset, ext_data;
    size_e           size_in;

    size_e           q_size;
    logic            q_signed;
    logic [REGW-1:0] q_rt, q_ra;
    logic [XLEN-1:0] q_base, q_next, q_data;

    assign size_in  = size_e'(op_size);
    assign form_bad = (op_ra == '0) || (op_ra == op_rt);

    pinc_offset #(.XLEN(XLEN), .IMMW(IMMW)) u_offset (
        .indexed (op_indexed),
        .size    (size_in),
        .imm     (op_imm),
        .rb      (op_rb_val),
        .offset  (offset)
    );

    pinc_extend #(.XLEN(XLEN)) u_extend (
        .size    (q_size),
        .sign_en (q_signed),
        .rdata   (mem_rdata),
        .result  (ext_data)
    );

    pinc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .form_bad   (form_bad),
        .mem_rvalid (mem_rvalid),
        .take_op    (take_op),
        .take_data  (take_data),
        .busy       (busy),
        .mem_req    (mem_req),
        .wb_en      (wb_en),
        .invalid    (invalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_size   <= SZ_B1;
            q_signed <= 1'b0;
            q_rt     <= '0;
            q_ra     <= '0;
            q_base   <= '0;
            q_next   <= '0;
            q_data   <= '0;
        end else begin
            if (take_op) begin
                q_size   <= size_in;
                q_signed <= op_signed;
                q_rt     <= op_rt;
                q_ra     <= op_ra;
                q_base   <= op_ra_val;
                q_next   <= op_ra_val + offset;
            end
            if (take_data)
                q_data <= ext_data;
        end
    end

    assign mem_addr = q_base;
    assign mem_size = q_size;
    assign rt_we    = wb_en;
    assign ra_we    = wb_en;
    assign rt_waddr = q_rt;
    assign ra_waddr = q_ra;
    assign rt_wdata = q_data;
    assign ra_wdata = q_next;

    assert_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));
    assert_ports_distinct_R7: assert property (@(posedge clk) disable iff (rst)
        rt_we |-> (ra_waddr != rt_waddr && ra_waddr != '0));
    assert_write_after_rvalid_R8: assert property (@(posedge clk) disable iff (rst)
        rt_we |-> $past(mem_rvalid));
endmodule

// File: tb/pinc_load_unit_tb.sv
module pinc_load_unit_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        op_valid = 0, op_signed = 0, op_indexed = 0;
    logic [1:0]  op_size = 0;
    logic [4:0]  op_rt = 0, op_ra = 0;
    logic [63:0] op_ra_val = 0, op_rb_val = 0;
    logic [15:0] op_imm = 0;
    logic        mem_rvalid = 0;
    logic [63:0] mem_rdata = 0;
    logic        busy, mem_req, rt_we, ra_we, invalid;
    logic [63:0] mem_addr, rt_wdata, ra_wdata;
    logic [1:0]  mem_size;
    logic [4:0]  rt_waddr, ra_waddr;

    int n_vec = 0, n_bad = 0;
    bit checking = 0;

    always #4 clk = ~clk;

    pinc_load_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_size(op_size),
        .op_signed(op_signed), .op_indexed(op_indexed), .op_rt(op_rt),
        .op_ra(op_ra), .op_ra_val(op_ra_val), .op_rb_val(op_rb_val),
        .op_imm(op_imm), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rt_we(rt_we), .rt_waddr(rt_waddr), .rt_wdata(rt_wdata),
        .ra_we(ra_we), .ra_waddr(ra_waddr), .ra_wdata(ra_wdata),
        .invalid(invalid)
    );

    // reference model: phase 0 idle, 1 waiting, 2 write, 3 reject
    int          m_phase = 0;
    logic [63:0] m_addr, m_next, m_data;
    logic [4:0]  m_rt, m_ra;
    int          m_size;
    bit          m_sgn;

    function automatic logic [63:0] fmt(int sz, bit sgn, logic [63:0] d);
        longint v;
        case (sz)
            0: v = longint'(d[7:0]);
            1: v = sgn ? longint'($signed(d[15:0])) : longint'(d[15:0]);
            2: v = sgn ? longint'($signed(d[31:0])) : longint'(d[31:0]);
            default: v = longint'(d);
        endcase
        return 64'(v);
    endfunction

    function automatic logic [63:0] offs(bit idx, int sz, logic [15:0] imm, logic [63:0] rb);
        longint v;
        if (idx) return rb;
        v = longint'($signed(imm));
        if (sz == 3) v = v & ~longint'(3);
        return 64'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) m_phase <= 0;
        else case (m_phase)
            0: if (op_valid) begin
                m_rt   <= op_rt;  m_ra <= op_ra;
                m_size <= int'(op_size); m_sgn <= op_signed;
                m_addr <= op_ra_val;
                m_next <= op_ra_val + offs(op_indexed, int'(op_size), op_imm, op_rb_val);
                m_phase <= (op_ra == 0 || op_ra == op_rt) ? 3 : 1;
            end
            1: if (mem_rvalid) begin
                m_data  <= fmt(m_size, m_sgn, mem_rdata);
                m_phase <= 2;
            end
            default: m_phase <= 0;
        endcase
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) if (checking) begin
        n_vec++;
        chk("R9 busy", 64'(busy), 64'(m_phase != 0));
        chk("R1 mem_req", 64'(mem_req), 64'(m_phase == 1));
        chk("R7 invalid", 64'(invalid), 64'(m_phase == 3));
        chk("R8 rt_we", 64'(rt_we), 64'(m_phase == 2));
        chk("R8 ra_we", 64'(ra_we), 64'(m_phase == 2));
        if (m_phase == 1) begin
            chk("R1 mem_addr", mem_addr, m_addr);
            chk("R4 mem_size", 64'(mem_size), 64'(m_size));
        end
        if (m_phase == 2) begin
            chk("R4 R5 R6 rt_wdata", rt_wdata, m_data);
            chk("R2 R3 ra_wdata", ra_wdata, m_next);
            chk("R8 rt_waddr", 64'(rt_waddr), 64'(m_rt));
            chk("R8 ra_waddr", 64'(ra_waddr), 64'(m_ra));
        end
    end

    task automatic run_op(int sz, bit sgn, bit idx, int rt, int ra,
                          logic [63:0] rav, logic [63:0] rbv, logic [15:0] imm,
                          logic [63:0] data, int lat);
        @(negedge clk);
        op_valid = 1; op_size = 2'(sz); op_signed = sgn; op_indexed = idx;
        op_rt = 5'(rt); op_ra = 5'(ra); op_ra_val = rav; op_rb_val = rbv; op_imm = imm;
        @(negedge clk);
        op_valid = 0;
        if (ra == 0 || ra == rt) begin
            @(negedge clk);
            return;
        end
        for (int i = 0; i < lat; i++) begin
            // R9: stray issue while busy must be ignored
            op_valid = 1; op_ra_val = ~rav; op_rb_val = 64'h5; op_imm = 16'h7777;
            op_ra = 5'd9; op_rt = 5'd10; op_size = 2'(sz + 1);
            @(negedge clk);
            op_valid = 0;
        end
        mem_rvalid = 1; mem_rdata = data;
        @(negedge clk);
        mem_rvalid = 0; mem_rdata = ~data;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        checking = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset busy", 64'(busy), 0);
        chk("R10 reset we", 64'({rt_we, ra_we, mem_req, invalid}), 0);
        // R4 zero-extending loads with garbage above
        run_op(0, 0, 0, 3, 4, 64'h1000, 0, 16'h0010, 64'hDEAD_BEEF_CAFE_F0A5, 0);
        run_op(1, 0, 0, 3, 4, 64'h2000, 0, 16'hFFF0, 64'hDEAD_BEEF_CAFE_8123, 1);
        run_op(2, 0, 1, 5, 6, 64'h3000, 64'hFFFF_FFFF_FFFF_F000, 0, 64'h1234_5678_9ABC_DEF0, 2);
        // R5 algebraic, and ignored for byte and dword
        run_op(1, 1, 0, 7, 8, 64'h4000, 0, 16'h0002, 64'h0000_0000_0000_8001, 3);
        run_op(2, 1, 1, 7, 8, 64'h5000, 64'h8, 0, 64'hFFFF_0000_8000_0001, 0);
        run_op(2, 1, 0, 7, 8, 64'h5100, 0, 16'h0003, 64'h0000_0000_7FFF_FFFF, 1);
        run_op(0, 1, 0, 7, 8, 64'h5200, 0, 16'h0001, 64'h0000_0000_0000_00FF, 0);
        // R6 and R3 dword with scaled immediate
        run_op(3, 1, 0, 11, 12, 64'h6000, 0, 16'h0007, 64'hFEDC_BA98_7654_3210, 2);
        run_op(3, 0, 0, 11, 12, 64'h7000, 0, 16'hFFFF, 64'h8000_0000_0000_0001, 1);
        run_op(2, 0, 0, 11, 12, 64'h7100, 0, 16'h8003, 64'h8000_0000_8000_0000, 0);
        // R2 indexed wrap past zero
        run_op(3, 0, 1, 13, 31, 64'h10, 64'hFFFF_FFFF_FFFF_FFE0, 0, 64'h1, 4);
        // R7 invalid forms
        run_op(2, 0, 0, 3, 0, 64'h8000, 0, 16'h4, 64'h0, 0);
        run_op(1, 1, 1, 9, 9, 64'h8100, 64'h4, 0, 64'h0, 0);
        run_op(0, 0, 0, 0, 1, 64'h8200, 0, 16'h1, 64'hAB, 1);
        // R10 reset mid-operation
        @(negedge clk);
        op_valid = 1; op_size = 2; op_ra = 4; op_rt = 5;
        @(negedge clk);
        op_valid = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 reset clears pending", 64'({busy, mem_req}), 0);
        repeat (3) @(negedge clk);
        checking = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule